// File: doc/BRIEF.md
# Two-Half Trigger Combiner with Fixed-Length Stretcher

This block forms the acquisition trigger of a module built from two halves, each with two ADC channels. Every half sees three signals: an external front-panel trigger shared by both halves, and the two discriminator outputs of its own channels. A per-half 8-bit truth table, loaded from configuration inputs, turns the three signals into a half trigger. The two half triggers are ORed into one module trigger.

The module trigger opens a window of fixed length. With the default of 624 cycles, the window covers four front-end chips that each send 128 data words and 8 trailer words, plus 80 cycles for common-mode work and margin. The block drives the stretched level, a one-cycle start pulse when the window opens and a one-cycle done pulse when it closes. Downstream logic uses the done pulse to build the event header. A typical table uses the external trigger as an enable, so that a discriminator counts only while the external trigger is present.

Top module: `trig_stretch`

## Requirements
- R1: While rst_n is low, and on the first clock after it is released, trig_out, start_pulse and done_pulse are all 0.
- R2: A half trigger equals bit {ext_trig, disc1, disc0} of that half's table. The index is ext_trig*4 + disc1*2 + disc0, where disc0 and disc1 are bits 0 and 1 of that half's discriminator bus. An index whose bit is 0 never opens a window.
- R3: The module trigger is the OR of the half-A and half-B triggers. Either half alone opens a window.
- R4: Every input passes through two synchronizing flops. trig_out rises on the third rising clock edge after a qualifying pattern is first sampled.
- R5: Once open, trig_out stays high for exactly STRETCH_LEN consecutive cycles (default 624).
- R6: A qualifying trigger that arrives while the window is open neither restarts nor lengthens the window.
- R7: start_pulse is high for exactly one cycle, the first cycle in which trig_out is high, and at no other time.
- R8: done_pulse is high for exactly one cycle, the first cycle in which trig_out is low after a window, and at no other time.
- R9: At least one low cycle separates two windows. A trigger condition still present in that low cycle opens the next window one cycle after the previous window closes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_trig | input | 1 | External trigger, shared by both halves, asynchronous |
| disc_a | input | 2 | Discriminator outputs of half A, asynchronous |
| disc_b | input | 2 | Discriminator outputs of half B, asynchronous |
| lut_a | input | 8 | Truth table of half A |
| lut_b | input | 8 | Truth table of half B |
| trig_out | output | 1 | Stretched module trigger |
| start_pulse | output | 1 | One-cycle pulse as the window opens |
| done_pulse | output | 1 | One-cycle pulse as the window closes |

## Verification
Each fault in the internal state shows up at the ports within one window.

- **Window counter:** a wrong counter value shows as a window that is not 624 cycles long. It is detected on the cycle the window closes.
- **Synchronizer stage:** a missing or extra stage moves the rising edge of trig_out away from the third edge after the input. It is detected on the first trigger.
- **Truth-table index:** a wrong bit order opens windows for patterns that should be masked, or misses patterns that should open one. It is detected within three cycles of the stimulus.
- **Retrigger guard:** a faulty guard lengthens the window, or restarts it and issues an extra start pulse. It is detected when the window closes.

// File: rtl/trig_stretch.sv
module trig_stretch #(
  parameter int STRETCH_LEN = 624,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ext_trig,
  input  logic [1:0] disc_a,
  input  logic [1:0] disc_b,
  input  logic [7:0] lut_a,
  input  logic [7:0] lut_b,
  output logic       trig_out,
  output logic       start_pulse,
  output logic       done_pulse
);
  localparam int CW = $clog2(STRETCH_LEN + 1);

  logic [SYNC_STAGES-1:0][4:0] sync;
  logic [4:0]    s;
  logic          half_a, half_b, fire, last;
  logic          active, start_q, done_q;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync <= '0;
    else        sync <= {sync[SYNC_STAGES-2:0], {ext_trig, disc_b, disc_a}};

  assign s      = sync[SYNC_STAGES-1];
  assign half_a = lut_a[{s[4], s[1], s[0]}];
  assign half_b = lut_b[{s[4], s[3], s[2]}];
  assign fire   = (half_a | half_b) & ~active;
  assign last   = active && (cnt == CW'(STRETCH_LEN - 1));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      active  <= 1'b0;
      cnt     <= '0;
      start_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      start_q <= fire;
      done_q  <= last;
      if (fire) begin
        active <= 1'b1;
        cnt    <= '0;
      end else if (last) begin
        active <= 1'b0;
      end else if (active) begin
        cnt <= cnt + 1'b1;
      end
    end

  assign trig_out    = active;
  assign start_pulse = start_q;
  assign done_pulse  = done_q;

  logic [CW:0] obs_len;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        obs_len <= '0;
    else if (trig_out) obs_len <= obs_len + 1'b1;
    else               obs_len <= '0;

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |=> !trig_out && !start_pulse && !done_pulse);
  assert_window_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(trig_out) |-> obs_len == (CW+1)'(STRETCH_LEN));
  assert_no_extend_R6: assert property (@(posedge clk) disable iff (!rst_n)
    obs_len <= (CW+1)'(STRETCH_LEN));
  assert_start_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trig_out) |-> start_pulse);
  assert_start_in_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |-> trig_out && obs_len == '0);
  assert_done_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(trig_out) |-> done_pulse);
  assert_done_outside_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |-> !trig_out);
  assert_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |-> !start_pulse);
endmodule

// File: tb/test_trig_stretch.sv
module test_trig_stretch;
  localparam int LEN = 624;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ext_trig = 1'b0;
  logic [1:0] disc_a = '0, disc_b = '0;
  logic [7:0] lut_a = '0, lut_b = '0;
  logic trig_out, start_pulse, done_pulse;

  int checks = 0, fails = 0, cyc = 0;
  int exp_q[$];
  bit done_run = 1'b0;

  trig_stretch #(.STRETCH_LEN(LEN), .SYNC_STAGES(2)) i_trig_stretch (
    .clk(clk), .rst_n(rst_n), .ext_trig(ext_trig), .disc_a(disc_a), .disc_b(disc_b),
    .lut_a(lut_a), .lut_b(lut_b), .trig_out(trig_out),
    .start_pulse(start_pulse), .done_pulse(done_pulse));

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
    end
  endtask

  // driver: apply pattern for one cycle, push expected start cycle if it qualifies
  task automatic pulse(input bit e, input logic [1:0] a, input logic [1:0] b, input bit expect_start);
    @(negedge clk);
    ext_trig = e; disc_a = a; disc_b = b;
    if (expect_start) exp_q.push_back(cyc + 3);
    @(negedge clk);
    ext_trig = 1'b0; disc_a = '0; disc_b = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: scoreboard of window starts plus length and edge-pulse checks
  initial begin
    bit prev = 1'b0;
    int len = 0;
    forever begin
      @(posedge clk); #5;
      if (!rst_n) continue;
      if (start_pulse) begin
        if (exp_q.size() == 0) chk(1'b0, "R6 unexpected start", cyc, -1);
        else begin
          int e;
          e = exp_q.pop_front();
          chk(cyc == e, "R4 start cycle", cyc, e);
        end
        chk(trig_out && !prev, "R7 start on first high cycle", trig_out, 1);
      end else if (trig_out && !prev) begin
        chk(1'b0, "R7 missing start", 0, 1);
      end
      if (trig_out) len++;
      else if (prev) begin
        chk(len == LEN, "R5 window length", len, LEN);
        chk(done_pulse, "R8 done after fall", done_pulse, 1);
        len = 0;
      end else if (done_pulse) begin
        chk(1'b0, "R8 spurious done", 1, 0);
      end
      if (trig_out && done_pulse) chk(1'b0, "R8 done inside window", 1, 0);
      prev = trig_out;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_run) begin
      chk(1'b0, "watchdog", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!trig_out && !start_pulse && !done_pulse, "R1 reset outputs", trig_out, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!trig_out && !start_pulse && !done_pulse, "R1 after release", trig_out, 0);

    // R2: half A enabled by external trigger: ext & (d0 | d1) -> indices 5,6,7
    lut_a = 8'hE0; lut_b = 8'h00;
    pulse(1'b0, 2'b11, 2'b00, 1'b0);
    idle(8);
    chk(!trig_out, "R2 discriminators without ext", trig_out, 0);
    pulse(1'b1, 2'b00, 2'b00, 1'b0);
    idle(8);
    chk(!trig_out, "R2 ext without discriminator", trig_out, 0);
    pulse(1'b1, 2'b00, 2'b11, 1'b0);
    idle(8);
    chk(!trig_out, "R2 half B table empty", trig_out, 0);
    pulse(1'b1, 2'b01, 2'b00, 1'b1);
    idle(LEN + 10);
    chk(exp_q.size() == 0, "R2 half A window seen", exp_q.size(), 0);

    // R3: half B alone, table index 1 (disc0 without ext)
    lut_a = 8'h00; lut_b = 8'h02;
    pulse(1'b0, 2'b01, 2'b00, 1'b0);
    idle(8);
    chk(!trig_out, "R3 half A pattern with empty table", trig_out, 0);
    pulse(1'b0, 2'b00, 2'b01, 1'b1);
    idle(LEN + 10);
    chk(exp_q.size() == 0, "R3 half B window seen", exp_q.size(), 0);

    // R3: both halves enabled, index 2 of half A (disc1 only)
    lut_a = 8'h04; lut_b = 8'h02;
    pulse(1'b0, 2'b10, 2'b00, 1'b1);
    idle(LEN + 10);

    // R6: retriggers during an open window
    pulse(1'b0, 2'b10, 2'b00, 1'b1);
    idle(100);
    pulse(1'b0, 2'b00, 2'b01, 1'b0);
    idle(300);
    pulse(1'b0, 2'b10, 2'b01, 1'b0);
    idle(LEN);
    chk(!trig_out, "R6 window not extended", trig_out, 0);

    // R9: external trigger held; ext-only table index 4
    lut_a = 8'h10; lut_b = 8'h00;
    @(negedge clk);
    ext_trig = 1'b1;
    exp_q.push_back(cyc + 3);
    exp_q.push_back(cyc + 3 + LEN + 1);
    idle(LEN + 8);
    ext_trig = 1'b0;
    idle(LEN + 10);
    chk(exp_q.size() == 0, "R9 back-to-back windows", exp_q.size(), 0);
    chk(!trig_out && !start_pulse, "R9 quiet after release", trig_out, 0);

    done_run = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule